// File: doc/BRIEF.md
# Half-Integer Clock Divider

This block derives a slower clock from a reference clock. It offers a fixed menu of 22 divisors. The menu covers every half step from 1.5 to 8 and every integer from 9 to 16. The divisor is counted against the "input clock", which is taken to run at half the reference rate. Reference clock `clk_ref` rising edges are numbered 0, 1, 2, … starting at the first edge after reset is released. The input clock rises on the even-numbered edges. Because the block counts reference cycles, it can place output edges on half input periods. A divisor D therefore gives an output period of exactly 2·D reference cycles.

A five-bit code picks the divisor. A mode input picks how an odd reference count is split between the high and low phases:
- In normal mode, the falling edge moves onto the falling edge of the reference clock, which keeps the output at 50/50.
- In high-frequency mode, the output stays on rising reference edges only, and the high phase is one reference cycle shorter than the low phase.

A code outside the menu raises an error flag and parks the output low. A change of code or mode is picked up only at the next output rising edge, so the output never shows a runt pulse. `rst_n` is asynchronous and active low. It is assumed to be released in step with `clk_ref` by a reset synchronizer outside this block.

Top module: `hdiv_clock_gen`

## Requirements
- R1: Code k from 0 to 13 selects D = 1.5 + 0.5·k, and code k from 14 to 21 selects D = k − 5. With a steady legal code, consecutive output rising edges are exactly 2·D reference cycles apart.
- R2: For codes 22 to 31, `sel_err_o` is high in the same cycle the code is applied, and the output remains low. For codes 0 to 21, `sel_err_o` is low.
- R3: With an integer D, the output is high for D reference cycles and low for D reference cycles.
- R4: In normal mode (`hf_mode`=0) with a half-integer D, the output is high for D reference cycles and low for D reference cycles. The falling edge lands on a falling edge of `clk_ref`.
- R5: In high-frequency mode (`hf_mode`=1) with a half-integer D, the output is high for D − 0.5 reference cycles and low for D + 0.5 reference cycles. Both of its edges fall on rising edges of `clk_ref`.
- R6: While `rst_n` is low, the output is low. When a legal code is present at release, the first output rising edge occurs at reference edge 0, which is an input rising edge.
- R7: If the code or mode changes during an output period, that period completes with the old setting. The new setting applies from the next output rising edge.
- R8: Suppose an illegal code is present at the end of a period. The output then stays low until a legal code is present. It restarts on the first even-numbered reference edge at which a legal code is seen.
- R9: With an integer D, every output rising edge lands on an even-numbered reference edge, so it coincides with an input rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock at twice the input clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hf_mode | input | 1 | 0 = normal mode, 1 = high-frequency mode |
| div_sel | input | 5 | Divisor selection code |
| clk_div_o | output | 1 | Divided clock |
| sel_err_o | output | 1 | High while `div_sel` is outside the legal menu |

## Verification
The divider is driven through every legal code in both modes and through every illegal code. The output is sampled twice per reference cycle, and each capture is compared against a waveform computed from the period and high-time arithmetic.
- A counter that wraps at the wrong count shows up within one output period as a shifted rising edge.
- A wrong high-time limit, or a missing half-cycle extension, shows up at the first falling edge.
- Configuration that is reloaded too early is caught by changing the code mid-period. The resulting distortion appears within the same period.
- A restart on the wrong input phase is caught one reference cycle after the legal code returns.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

  // Smallest period in reference cycles (divisor 1.5).
  localparam int unsigned HDIV_MIN_PERIOD = 3;

  // Number of legal codes for a given top of the half-step range
  // (expressed as a period, 2*D) and a given top integer divisor.
  function automatic int unsigned hdiv_code_count(input int unsigned half_top2,
                                                  input int unsigned int_top);
    return (half_top2 - HDIV_MIN_PERIOD + 1) + (int_top - half_top2 / 2);
  endfunction

endpackage

// File: rtl/hdiv_sel_decode.sv
module hdiv_sel_decode
  import hdiv_pkg::*;
#(
  parameter int unsigned SEL_W     = 5,
  parameter int unsigned HALF_TOP2 = 16,
  parameter int unsigned INT_TOP   = 16,
  parameter int unsigned PER_W     = 6
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic             legal_o,
  output logic [PER_W-1:0] period_o
);

  localparam int unsigned N_HALF  = HALF_TOP2 - HDIV_MIN_PERIOD + 1;
  localparam int unsigned N_CODES = hdiv_code_count(HALF_TOP2, INT_TOP);

  always_comb begin
    int unsigned k;
    k        = int'(sel_i);
    legal_o  = 1'b0;
    period_o = '0;
    if (k < N_HALF) begin
      legal_o  = 1'b1;
      period_o = PER_W'(k + HDIV_MIN_PERIOD);
    end else if (k < N_CODES) begin
      legal_o  = 1'b1;
      period_o = PER_W'(2 * (k - N_HALF + HALF_TOP2 / 2 + 1));
    end
  end

  // R1: every legal period lies inside the supported span
  always_comb begin
    if (legal_o) begin
      a_per_span_r1: assert (period_o >= PER_W'(HDIV_MIN_PERIOD) &&
                             period_o <= PER_W'(2 * INT_TOP))
        else $error("decoded period out of span");
    end
  end

endmodule

// File: rtl/hdiv_period_ctr.sv
module hdiv_period_ctr #(
  parameter int unsigned PER_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             legal_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             fast_i,
  output logic             pos_o,
  output logic             stretch_o
);

  logic             ph_q, ph_d;
  logic             run_q, run_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             pos_q, pos_d;
  logic [PER_W-1:0] per_q, hi_q;
  logic             stretch_q;
  logic             wrap, cfg_en, stop;

  // next-state logic
  always_comb begin
    ph_d   = ~ph_q;
    wrap   = run_q && (cnt_q == per_q - 1'b1);
    cfg_en = (wrap && legal_i) || (!run_q && legal_i && !ph_q);
    stop   = wrap && !legal_i;
    run_d  = run_q;
    cnt_d  = cnt_q;
    pos_d  = pos_q;
    if (cfg_en) begin
      run_d = 1'b1;
      cnt_d = '0;
      pos_d = 1'b1;
    end else if (stop) begin
      run_d = 1'b0;
      cnt_d = '0;
      pos_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q + 1'b1;
      pos_d = (cnt_q + 1'b1) < hi_q;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      run_q <= 1'b0;
      cnt_q <= '0;
      pos_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      run_q <= run_d;
      cnt_q <= cnt_d;
      pos_q <= pos_d;
    end
  end

  // configuration registers, enabled only at a period start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q     <= '0;
      hi_q      <= '0;
      stretch_q <= 1'b0;
    end else if (cfg_en) begin
      per_q     <= period_i;
      hi_q      <= period_i >> 1;
      stretch_q <= period_i[0] & ~fast_i;
    end
  end

  assign pos_o     = pos_q;
  assign stretch_o = stretch_q;

  // R1: counter never reaches the latched period
  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < per_q));

  // R1: the output only rises at the start of a period
  p_rise_at_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pos_q) |-> (run_q && cnt_q == '0));

  // R2: a stopped divider keeps its output low
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !pos_q);

  // R3: the rising-edge phase never exceeds the latched high time
  p_high_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q |-> (cnt_q < hi_q));

  // R7: the configuration holds inside a period
  p_hold_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && cnt_q != '0) |-> ($stable(per_q) && $stable(stretch_q)));

  // R8: a restart from idle happens on an input rising edge only
  p_start_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> ($past(ph_q) == 1'b0));

endmodule

// File: rtl/hdiv_edge_shaper.sv
module hdiv_edge_shaper (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_i,
  input  logic stretch_i,
  output logic clk_o
);

  logic neg_q;

  // half-cycle delayed copy, captured on the falling reference edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= pos_i;
  end

  assign clk_o = pos_i | (neg_q & stretch_i);

  // R4: in normal mode an odd count keeps the output up for an extra half cycle
  p_half_extend_r4: assert property (@(negedge clk) disable iff (!rst_n)
    ($fell(pos_i) && stretch_i) |-> clk_o);

  // R5: without stretch the output falls together with the rising-edge phase
  p_no_extend_r5: assert property (@(negedge clk) disable iff (!rst_n)
    ($fell(pos_i) && !stretch_i) |-> !clk_o);

endmodule

// File: rtl/hdiv_clock_gen.sv
module hdiv_clock_gen
  import hdiv_pkg::*;
#(
  parameter int unsigned SEL_W     = 5,
  parameter int unsigned HALF_TOP2 = 16,
  parameter int unsigned INT_TOP   = 16
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             hf_mode,
  input  logic [SEL_W-1:0] div_sel,
  output logic             clk_div_o,
  output logic             sel_err_o
);

  localparam int unsigned PER_W = $clog2(2 * INT_TOP + 1);

  logic             legal;
  logic [PER_W-1:0] period;
  logic             pos, stretch;

  hdiv_sel_decode #(
    .SEL_W    (SEL_W),
    .HALF_TOP2(HALF_TOP2),
    .INT_TOP  (INT_TOP),
    .PER_W    (PER_W)
  ) u_decode (
    .sel_i   (div_sel),
    .legal_o (legal),
    .period_o(period)
  );

  hdiv_period_ctr #(
    .PER_W(PER_W)
  ) u_ctr (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .legal_i  (legal),
    .period_i (period),
    .fast_i   (hf_mode),
    .pos_o    (pos),
    .stretch_o(stretch)
  );

  hdiv_edge_shaper u_shape (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .pos_i    (pos),
    .stretch_i(stretch),
    .clk_o    (clk_div_o)
  );

  assign sel_err_o = ~legal;

endmodule

// File: tb/hdiv_clock_gen_test.sv
`timescale 1ns/1ps
module hdiv_clock_gen_test;

  logic       clk;
  logic       rst_n;
  logic       hf_mode;
  logic [4:0] div_sel;
  logic       clk_div_o;
  logic       sel_err_o;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 0;
  bit  outb [0:511];
  bit  errb [0:511];

  hdiv_clock_gen uut (
    .clk_ref  (clk_ref_w),
    .rst_n    (rst_n),
    .hf_mode  (hf_mode),
    .div_sel  (div_sel),
    .clk_div_o(clk_div_o),
    .sel_err_o(sel_err_o)
  );

  wire clk_ref_w = clk;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // period in reference cycles from the code, per R1
  function automatic int per_of(input int k);
    return (k < 14) ? k + 3 : 2 * (k - 5);
  endfunction

  // high time in half reference cycles, per R3/R4/R5
  function automatic int hi_of(input int p, input bit fast);
    return ((p % 2 == 1) && fast) ? p - 1 : p;
  endfunction

  task automatic start_case(input int code, input bit mode);
    rst_n   = 1'b0;
    div_sel = 5'(code);
    hf_mode = mode;
    repeat (2) @(posedge clk);
    #3;
    chk(clk_div_o == 1'b0, "R6 reset low", int'(clk_div_o), 0);
    rst_n = 1'b1;
  endtask

  // captures two samples per reference cycle; optional input changes late in a cycle
  task automatic capture(input int ncyc, input int c1, input int s1, input bit m1,
                         input int c2, input int s2);
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk);
      #2.5;
      outb[2*c] = clk_div_o;
      errb[2*c] = sel_err_o;
      #5;
      outb[2*c+1] = clk_div_o;
      errb[2*c+1] = sel_err_o;
      if (c == c1) begin
        div_sel = 5'(s1);
        hf_mode = m1;
      end
      if (c == c2) div_sel = 5'(s2);
    end
  endtask

  function automatic bit exp_bit(input int h, input int p1, input int h1,
                                 input int p2, input int h2);
    if (h < 2 * p1) return h < h1;
    return ((h - 2 * p1) % (2 * p2)) < h2;
  endfunction

  task automatic cmp_wave(input string req, input int nh, input int p1, input int h1,
                          input int p2, input int h2);
    int bad;
    bad = -1;
    for (int h = 0; h < nh; h++)
      if (bad < 0 && outb[h] != exp_bit(h, p1, h1, p2, h2)) bad = h;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, int'(outb[bad]), int'(exp_bit(bad, p1, h1, p2, h2)));
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    hf_mode = 1'b0;
    div_sel = '0;

    // R1 R3 R4 R5 R9: every legal code in both modes
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 22; k++) begin
        int    p, hh, errs;
        string req;
        p  = per_of(k);
        hh = hi_of(p, bit'(m));
        if (p % 2 == 0)  req = $sformatf("R1 R3 R9 code %0d mode %0d", k, m);
        else if (m == 0) req = $sformatf("R1 R4 R6 code %0d mode %0d", k, m);
        else             req = $sformatf("R1 R5 R6 code %0d mode %0d", k, m);
        start_case(k, bit'(m));
        capture(3 * p, -1, 0, 1'b0, -1, 0);
        cmp_wave(req, 6 * p, p, hh, p, hh);
        errs = 0;
        for (int h = 0; h < 6 * p; h++) errs += int'(errb[h]);
        chk(errs == 0, $sformatf("R2 legal code %0d", k), errs, 0);
      end
    end

    // R2: illegal codes raise the flag and keep the output low
    for (int k = 22; k < 32; k++) begin
      int highs, errs;
      start_case(k, 1'b0);
      capture(20, -1, 0, 1'b0, -1, 0);
      highs = 0;
      errs  = 0;
      for (int h = 0; h < 40; h++) begin
        highs += int'(outb[h]);
        errs  += int'(errb[h]);
      end
      chk(highs == 0, $sformatf("R2 output low code %0d", k), highs, 0);
      chk(errs == 40, $sformatf("R2 flag high code %0d", k), errs, 40);
    end

    // R7: mid-period change to code 4 (D=3.5) in high-frequency mode
    start_case(2, 1'b0);
    capture(5 + 14 * 2, 1, 4, 1'b1, -1, 0);
    cmp_wave("R7 change at next rise", 2 * (5 + 28), 5, 5, 7, 6);

    // R8: illegal code stops the output at the period end; legal code restarts on even edge
    start_case(0, 1'b0);
    capture(6 + 4 * 3, 0, 25, 1'b0, 4, 1);
    begin
      int bad, e;
      bad = -1;
      e   = 0;
      for (int h = 0; h < 2 * 18; h++) begin
        e = (h < 6) ? int'(h < 3) : (h < 12) ? 0 : int'(((h - 12) % 8) < 4);
        if (bad < 0 && int'(outb[h]) != e) bad = h;
      end
      if (bad < 0) chk(1'b1, "R8 restart phase", 0, 0);
      else begin
        e = (bad < 6) ? int'(bad < 3) : (bad < 12) ? 0 : int'(((bad - 12) % 8) < 4);
        chk(1'b0, "R8 restart phase", int'(outb[bad]), e);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule